// File: doc/BRIEF.md
# RTC Serial Register Slave

This block sits inside an always-on real-time clock and lets a host reach two 32-bit registers over a slow bit-serial link. The link has a shift clock, an enable and a data line from the host, plus a data line and a ready flag back to it. A seconds counter advances once every `PRESCALE` ticks of a slow time base. A general-purpose-output control word is stored as written and read back unchanged.

All three host lines are brought into the system clock domain through synchronizer chains. Edges are then found on the synchronized levels. An enumerated controller tracks the frame through five states:

- `ST_IDLE`: ready high, waiting for the enable to rise.
- `ST_SHIFT`: enable high, each shift-clock rise shifts one bit into a 35-bit window.
- `ST_LAST`: entered when the enable falls, waiting for the single direction bit.
- `ST_READ`: the selected word is shifted out on 32 clock rises.
- `ST_COMMIT`: a one-cycle write into the selected register.

The transitions are:

- `ST_IDLE` to `ST_SHIFT` on an enable rise.
- `ST_SHIFT` to `ST_LAST` on an enable fall.
- `ST_LAST` to `ST_COMMIT` on a clock rise with data 1.
- `ST_LAST` to `ST_READ` on a clock rise with data 0.
- `ST_READ` to `ST_IDLE` on the 32nd clock rise.
- `ST_COMMIT` to `ST_IDLE` unconditionally.

A read frame is three select bits, MSB first, sent with the enable high, then a direction bit of 0 sent with the enable low, then 32 clock pulses. A write frame is 32 data bits, MSB first, then the three select bits, then a direction bit of 1 sent with the enable low.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the ready flag is high, the data output is low, and both registers read as zero.
- R2: An enable rise while ready starts a frame, and the ready flag is low within a few system cycles. An enable rise while a frame is in progress has no effect.
- R3: The address is 4 bits sent MSB first. Bits 3:1 select the register and bit 0 is the direction: 0 reads, 1 writes. Only bit 0 is clocked with the enable low.
- R4: On a read, the selected word leaves on the data output MSB first. After the k-th read pulse (k = 1..32) the output holds word bit 32-k, and it changes on no other event.
- R5: On a write, 32 data bits precede the address. The word is committed only when the final bit is 1. If the final bit is 0, the frame becomes a read of the addressed register and nothing is stored.
- R6: Select 1 stores all 32 written bits verbatim and returns them on read. This includes the command field in bits 21:20, polarity in bit 22, busy in bit 23, level in bit 24 and the count in bits 19:0.
- R7: Select 0 reads a seconds value that increments by one after every `PRESCALE` slow ticks and wraps at 2^32.
- R8: A write to select 0 loads the seconds value and clears the sub-second prescaler, so the next increment comes after a full `PRESCALE` further ticks.
- R9: Selects 2 to 7 read as zero. Writes to them leave both registers unchanged.
- R10: The ready flag returns high one cycle after a commit and right after the 32nd read bit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow time-base period |
| ser_clk | input | 1 | Host shift clock, sampled on its rising edge |
| ser_en | input | 1 | Host frame enable |
| ser_din | input | 1 | Host serial data into the block |
| ser_dout | output | 1 | Serial data to the host |
| ser_ready | output | 1 | High when a new frame may start |

## Verification
The bench builds the block with `PRESCALE` = 4 and the full 32-bit word width. With four ticks per second, every prescaler phase and several second increments can be swept tick by tick. Wrap-around from all-ones is reached with one load. With the full word width, walking-ones patterns exercise every bit position of the stored control word and of the shift-out order. All eight select values are swept for both reads and ignored writes.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

    localparam int unsigned SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SECONDS = 3'd0;
    localparam logic [SEL_W-1:0] SEL_GPO     = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LAST,
        ST_READ,
        ST_COMMIT
    } ser_state_e;

endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
        end

        assign level_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/rtc_ser_seconds.sv
module rtc_ser_seconds #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] seconds
);

    localparam int unsigned PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0]   prescale_q;
    logic [DATA_W-1:0] seconds_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prescale_q <= '0;
            seconds_q  <= '0;
        end else if (load) begin
            prescale_q <= '0;
            seconds_q  <= load_val;
        end else if (slow_tick) begin
            if (prescale_q == PS_LAST) begin
                prescale_q <= '0;
                seconds_q  <= seconds_q + 1'b1;
            end else begin
                prescale_q <= prescale_q + 1'b1;
            end
        end
    end

    assign seconds = seconds_q;

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned PRESCALE    = 32768,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic ser_clk,
    input  logic ser_en,
    input  logic ser_din,
    output logic ser_dout,
    output logic ser_ready
);

    import rtc_ser_pkg::*;

    localparam int unsigned FRAME_W = DATA_W + SEL_W;
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    // synchronized host lines: [0] clock, [1] enable, [2] data
    logic [2:0] lvl;
    logic [1:0] prev_q;
    logic       sclk_rise;
    logic       en_rise;
    logic       en_fall;
    logic       din;

    ser_state_e state_q;
    ser_state_e state_d;

    logic [FRAME_W-1:0] in_sr_q;
    logic [DATA_W-1:0]  out_sr_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic               dout_q;
    logic [DATA_W-1:0]  gpo_q;
    logic [DATA_W-1:0]  seconds_w;
    logic [DATA_W-1:0]  rd_word;
    logic [SEL_W-1:0]   sel;
    logic [DATA_W-1:0]  wr_word;
    logic               sec_load;

    rtc_ser_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  ({ser_din, ser_en, ser_clk}),
        .level_out (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl[1:0];
        end
    end

    assign sclk_rise = lvl[0] & ~prev_q[0];
    assign en_rise   = lvl[1] & ~prev_q[1];
    assign en_fall   = ~lvl[1] & prev_q[1];
    assign din       = lvl[2];

    assign sel     = in_sr_q[SEL_W-1:0];
    assign wr_word = in_sr_q[FRAME_W-1:SEL_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_rise) state_d = ST_SHIFT;
            ST_SHIFT:  if (en_fall) state_d = ST_LAST;
            ST_LAST:   if (sclk_rise) state_d = din ? ST_COMMIT : ST_READ;
            ST_READ:   if (sclk_rise && bit_cnt_q == CNT_LAST) state_d = ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // read source selection
    always_comb begin
        unique case (sel)
            SEL_SECONDS: rd_word = seconds_w;
            SEL_GPO:     rd_word = gpo_q;
            default:     rd_word = '0;
        endcase
    end

    assign sec_load = (state_q == ST_COMMIT) && (sel == SEL_SECONDS);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sr_q   <= '0;
            out_sr_q  <= '0;
            bit_cnt_q <= '0;
            dout_q    <= 1'b0;
            gpo_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (en_rise) begin
                        in_sr_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise) begin
                        in_sr_q <= {in_sr_q[FRAME_W-2:0], din};
                    end
                end
                ST_LAST: begin
                    if (sclk_rise && !din) begin
                        out_sr_q  <= rd_word;
                        bit_cnt_q <= '0;
                    end
                end
                ST_READ: begin
                    if (sclk_rise) begin
                        dout_q    <= out_sr_q[DATA_W-1];
                        out_sr_q  <= {out_sr_q[DATA_W-2:0], 1'b0};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                ST_COMMIT: begin
                    if (sel == SEL_GPO) begin
                        gpo_q <= wr_word;
                    end
                end
                default: ;
            endcase
        end
    end

    rtc_ser_seconds #(
        .DATA_W   (DATA_W),
        .PRESCALE (PRESCALE)
    ) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .load      (sec_load),
        .load_val  (wr_word),
        .seconds   (seconds_w)
    );

    assign ser_dout  = dout_q;
    assign ser_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/rtc_ser_chk.sv
module rtc_ser_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ser_ready,
    input logic                    ser_dout,
    input logic                    sclk_rise,
    input logic                    en_rise,
    input logic                    sec_load,
    input rtc_ser_pkg::ser_state_e state_q,
    input logic [DATA_W-1:0]       gpo_q,
    input logic [DATA_W-1:0]       seconds_w
);

    import rtc_ser_pkg::*;

    // R2
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_ready && en_rise) |=> !ser_ready);

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_READ && sclk_rise) |=> $stable(ser_dout));

    // R5
    gpo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMMIT) |=> $stable(gpo_q));

    // R7
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_load |=> (seconds_w == $past(seconds_w)
                       || seconds_w == $past(seconds_w) + 1'b1));

    // R10
    commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> ser_ready);

endmodule

bind rtc_serial_slave rtc_ser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_ready (ser_ready),
    .ser_dout  (ser_dout),
    .sclk_rise (sclk_rise),
    .en_rise   (en_rise),
    .sec_load  (sec_load),
    .state_q   (state_q),
    .gpo_q     (gpo_q),
    .seconds_w (seconds_w)
);

// File: tb/rtc_serial_slave_tb.sv
module rtc_serial_slave_tb;

    localparam int unsigned DW = 32;
    localparam int unsigned PS = 4;
    localparam int unsigned PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic ser_ready;

    int vectors = 0;
    int misses = 0;
    int ticks = 0;

    always #2 clk = ~clk;

    rtc_serial_slave #(.DATA_W(DW), .PRESCALE(PS), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .ser_clk   (ser_clk),
        .ser_en    (ser_en),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .ser_ready (ser_ready)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        ser_clk = 1'b1;
        cyc(PH);
        ser_clk = 1'b0;
        cyc(PH);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        cyc(PH);
        pulse();
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            cyc(1);
            slow_tick = 1'b0;
            cyc(1);
            ticks++;
        end
    endtask

    task automatic frame_start();
        check("R2 ready before frame", {31'd0, ser_ready}, 32'd1);
        ser_en = 1'b1;
        cyc(PH);
        check("R2 ready low in frame", {31'd0, ser_ready}, 32'd0);
    endtask

    task automatic send_addr(input logic [2:0] sel, input logic dir);
        for (int i = 2; i >= 0; i--) send_bit(sel[i]);
        ser_en = 1'b0;
        cyc(PH);
        send_bit(dir);
    endtask

    task automatic shift_out(output logic [DW-1:0] data);
        data = '0;
        for (int i = 0; i < DW; i++) begin
            pulse();
            data = {data[DW-2:0], ser_dout};
        end
        ser_din = 1'b0;
        check("R10 ready after read", {31'd0, ser_ready}, 32'd1);
    endtask

    task automatic do_read(input logic [2:0] sel, output logic [DW-1:0] data);
        frame_start();
        send_addr(sel, 1'b0);
        shift_out(data);
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [DW-1:0] word);
        frame_start();
        for (int i = DW - 1; i >= 0; i--) send_bit(word[i]);
        send_addr(sel, 1'b1);
        ser_din = 1'b0;
        check("R10 ready after commit", {31'd0, ser_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [DW-1:0] gpo_exp;
        logic [DW-1:0] sec_base;
        cyc(3);
        // R1 reset state
        check("R1 ready", {31'd0, ser_ready}, 32'd1);
        check("R1 dout", {31'd0, ser_dout}, 32'd0);
        rst_n = 1'b1;
        cyc(3);
        do_read(3'd0, rd);
        check("R1 seconds zero", rd, 32'd0);
        do_read(3'd1, rd);
        check("R1 gpo zero", rd, 32'd0);

        // R6 walking ones through the control word; R3 R4 bit order
        for (int b = 0; b < DW; b++) begin
            do_write(3'd1, 32'd1 << b);
            do_read(3'd1, rd);
            check("R6 walking one", rd, 32'd1 << b);
        end
        // R6 field composites: cmd, polarity, busy, level, count
        for (int c = 1; c <= 3; c++) begin
            gpo_exp = (32'(c) << 20) | (32'(c & 1) << 22) | (32'(c >> 1) << 23)
                      | (32'(c == 3) << 24) | 32'(c * 12345);
            do_write(3'd1, gpo_exp);
            do_read(3'd1, rd);
            check("R6 field word", rd, gpo_exp);
        end

        // R5 final bit 0: becomes a read, nothing stored
        frame_start();
        for (int i = DW - 1; i >= 0; i--) send_bit(~gpo_exp[i]);
        send_addr(3'd1, 1'b0);
        shift_out(rd);
        check("R5 final zero reads back", rd, gpo_exp);
        do_read(3'd1, rd);
        check("R5 final zero no store", rd, gpo_exp);

        // R9 unused selects
        for (int s = 2; s < 8; s++) begin
            do_write(3'(s), 32'hA5A5_0000 | 32'(s));
            do_read(3'(s), rd);
            check("R9 unused reads zero", rd, 32'd0);
        end
        do_read(3'd1, rd);
        check("R9 gpo untouched", rd, gpo_exp);
        do_read(3'd0, rd);
        check("R9 seconds untouched", rd, 32'd0);

        // R7 tick-by-tick sweep of seconds
        for (int n = 1; n <= 13; n++) begin
            tick(1);
            do_read(3'd0, rd);
            check("R7 seconds count", rd, 32'(ticks / PS));
        end

        // R8 load clears prescaler (13 ticks so far: prescaler mid-phase)
        sec_base = 32'h1234_5678;
        do_write(3'd0, sec_base);
        tick(PS - 1);
        do_read(3'd0, rd);
        check("R8 no step before full period", rd, sec_base);
        tick(1);
        do_read(3'd0, rd);
        check("R8 step after full period", rd, sec_base + 1);

        // R7 wrap from all ones
        do_write(3'd0, 32'hFFFF_FFFF);
        tick(PS);
        do_read(3'd0, rd);
        check("R7 wrap", rd, 32'd0);

        // R2 enable rise during read phase is ignored
        frame_start();
        send_addr(3'd1, 1'b0);
        rd = '0;
        for (int i = 0; i < DW; i++) begin
            if (i == 5) ser_en = 1'b1;
            if (i == 9) ser_en = 1'b0;
            pulse();
            rd = {rd[DW-2:0], ser_dout};
        end
        check("R2 busy enable ignored", rd, gpo_exp);
        cyc(PH);
        check("R2 ready after ignored enable", {31'd0, ser_ready}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule